// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block takes accepted Ethernet frames from a byte stream and files them into a packet memory that is organised as a circular ring of 256-byte pages. The ring is set by two page numbers: a first page, and a limit page that is the first page past the ring. The block owns a current-page pointer, which is where the next frame goes. Software owns a boundary pointer, which marks the oldest page it has not yet consumed. Each frame is laid down as a 4-byte header followed by its payload. Payload that reaches the limit page continues at the first page.

When a frame begins, the block checks whether the ring is certain to hold a maximum-size frame. If it is not, the whole frame is drained from the stream and nothing changes. Frames shorter than the minimum length are padded with zero bytes. The header is written last, once the length is known. It carries a status byte, the link to the page where the next frame will start, and the stored length. The current page then moves to that link page, and a receive interrupt request pulses for one cycle.

Top module: `rx_ring_writer`

## Requirements
- R1: After a synchronous reset, cur_page is 0, in_ready is 1, and mem_we and rx_irq are 0. All ring pointers are 0, so a frame sent straight after reset is refused.
- R2: A write on the configuration port loads a ring pointer. cfg_sel 0 loads the first page, 1 the limit page, 2 the boundary page and 3 the current page. The write takes effect only when no frame is in progress and no frame byte is taken in the same cycle; otherwise it is ignored.
- R3: Payload byte k of an accepted frame is written at byte address (cur_page << 8) + 4 + k, one byte per mem_we cycle. A frame of L bytes produces exactly max(L, 60) + 4 writes.
- R4: A frame shorter than 60 bytes is followed by zero bytes up to 60 stored bytes, and its stored length counts the padding.
- R5: After the payload, four header bytes are written at offsets 0, 1, 2 and 3 of the current page: 0x01 (received OK), the next page, the low byte of the total length, and the high byte of the total length. The total length is the stored length plus 4.
- R6: The next page is cur_page + ceil((total length + 4) / 256). If that reaches or passes the limit page, the ring size in pages is subtracted.
- R7: A payload or pad byte whose address reaches (limit page << 8) is written at (first page << 8) instead, and the bytes that follow continue from there.
- R8: rx_irq is high for exactly one cycle, in the same cycle as the header write at offset 3. cur_page shows the next page from that same cycle on.
- R9: A frame is refused when rx_run is 0, or when the limit page is not above the first page, or when cur_page lies outside the ring. A refused frame produces no memory write and no rx_irq, leaves cur_page unchanged, and has all of its bytes taken with in_ready held at 1.
- R10: Free space is (boundary − current) pages when current < boundary, and otherwise ring size − (current − boundary) pages, so equal pointers mean an empty ring. A frame is refused when free space × 256 is below 1518 bytes.
- R11: in_ready is 0 while padding and while the header is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_run | input | 1 | Receiver enabled |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Pointer select: 0 first, 1 limit, 2 boundary, 3 current |
| cfg_data | input | 8 | Page number to load |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | Frame byte valid |
| in_last | input | 1 | Final byte of the frame |
| in_ready | output | 1 | Frame byte taken when valid and ready |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_page | output | 8 | Current page pointer |
| rx_irq | output | 1 | One-cycle receive-OK interrupt request |

## Verification
A wrong length count or a wrong wrap pointer shows up in the memory write stream at the first byte that crosses the limit page. It also shows up four cycles after the last byte, when the header carries a wrong length or next page. A wrong free-space decision shows at once: writes either start or fail to start in the cycle after the first byte. A wrong next-page calculation is visible on cur_page from the rx_irq cycle on, and it corrupts the placement of the following frame. The vectors therefore cover page-rounding edges, an exactly sufficient ring, refusals just below the limit, and wrap-arounds that start in the last page.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DATA  = 3'd1,
    ST_PAD   = 3'd2,
    ST_HDR   = 3'd3,
    ST_DRAIN = 3'd4
  } rxr_state_e;

  typedef enum logic [1:0] {
    CFG_FIRST = 2'd0,
    CFG_LIMIT = 2'd1,
    CFG_BOUND = 2'd2,
    CFG_CURR  = 2'd3
  } rxr_cfg_e;

  localparam logic [7:0] RX_STATUS_OK = 8'h01;
  localparam int         HDR_BYTES    = 4;
  localparam int         CRC_BYTES    = 4;
endpackage

// File: rtl/rxr_space_chk.sv
module rxr_space_chk #(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int MAX_FRAME = 1514
) (
  input  logic              run,
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] limit_pg,
  input  logic [PAGE_W-1:0] bound_pg,
  input  logic [PAGE_W-1:0] cur_pg,
  output logic              room_ok
);
  localparam int FW   = PAGE_W + 1 + OFF_W;
  localparam int NEED = MAX_FRAME + rxr_pkg::HDR_BYTES;

  logic [PAGE_W:0] ring_pg, used_pg, free_pg;
  logic [FW-1:0]   free_bytes;
  logic            ring_valid, cur_inside;

  always_comb begin
    ring_pg = {1'b0, limit_pg} - {1'b0, first_pg};
    used_pg = '0;
    if (cur_pg < bound_pg) begin
      free_pg = {1'b0, bound_pg} - {1'b0, cur_pg};
    end else begin
      used_pg = {1'b0, cur_pg} - {1'b0, bound_pg};
      free_pg = (used_pg > ring_pg) ? '0 : (ring_pg - used_pg);
    end
    free_bytes = {free_pg, {OFF_W{1'b0}}};
    ring_valid = limit_pg > first_pg;
    cur_inside = (cur_pg >= first_pg) && (cur_pg < limit_pg);
    room_ok    = run && ring_valid && cur_inside && (free_bytes >= FW'(NEED));
  end
endmodule

// File: rtl/rxr_next_page.sv
module rxr_next_page #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  parameter int LEN_W  = 16
) (
  input  logic [PAGE_W-1:0] cur_pg,
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] limit_pg,
  input  logic [LEN_W-1:0]  total_len,
  output logic [PAGE_W-1:0] next_pg
);
  localparam int SW = LEN_W + PAGE_W + 2;

  logic [SW-1:0] span, pages, sum, ring, adj;

  always_comb begin
    span  = SW'(total_len) + SW'(rxr_pkg::CRC_BYTES) + SW'((1 << OFF_W) - 1);
    pages = span >> OFF_W;
    sum   = SW'(cur_pg) + pages;
    ring  = SW'(limit_pg) - SW'(first_pg);
    adj   = (sum >= SW'(limit_pg)) ? (sum - ring) : sum;
    next_pg = PAGE_W'(adj);
  end
endmodule

// File: rtl/rxr_wrap_addr.sv
module rxr_wrap_addr #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8
) (
  input  logic [PAGE_W+OFF_W-1:0] addr_in,
  input  logic [PAGE_W-1:0]       first_pg,
  input  logic [PAGE_W-1:0]       limit_pg,
  output logic [PAGE_W+OFF_W-1:0] addr_out
);
  localparam int ADDR_W = PAGE_W + OFF_W;

  logic [ADDR_W-1:0] inc;

  always_comb begin
    inc      = addr_in + ADDR_W'(1);
    addr_out = (inc == {limit_pg, {OFF_W{1'b0}}}) ? {first_pg, {OFF_W{1'b0}}} : inc;
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_run,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_sel,
  input  logic [PAGE_W-1:0]       cfg_data,
  input  logic [7:0]              in_data,
  input  logic                    in_valid,
  input  logic                    in_last,
  output logic                    in_ready,
  output logic                    mem_we,
  output logic [PAGE_W+OFF_W-1:0] mem_addr,
  output logic [7:0]              mem_wdata,
  output logic [PAGE_W-1:0]       cur_page,
  output logic                    rx_irq
);
  import rxr_pkg::*;

  localparam int ADDR_W = PAGE_W + OFF_W;

  rxr_state_e        state;
  logic [PAGE_W-1:0] first_pg, limit_pg, bound_pg, cur_pg, next_pg_r, next_comb;
  logic [ADDR_W-1:0] wr_addr, wr_next, base_addr;
  logic [LEN_W-1:0]  len_cnt, len_inc, total_len;
  logic [1:0]        hdr_idx;
  logic              room_ok;
  logic              mem_we_r, irq_r;
  logic [ADDR_W-1:0] mem_addr_r;
  logic [7:0]        mem_wdata_r;

  rxr_space_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .MAX_FRAME(MAX_FRAME)) u_space (
    .run(rx_run), .first_pg(first_pg), .limit_pg(limit_pg),
    .bound_pg(bound_pg), .cur_pg(cur_pg), .room_ok(room_ok)
  );

  rxr_next_page #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_next (
    .cur_pg(cur_pg), .first_pg(first_pg), .limit_pg(limit_pg),
    .total_len(total_len), .next_pg(next_comb)
  );

  rxr_wrap_addr #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_wrap (
    .addr_in(wr_addr), .first_pg(first_pg), .limit_pg(limit_pg), .addr_out(wr_next)
  );

  always_comb begin
    base_addr = {cur_pg, {OFF_W{1'b0}}};
    len_inc   = len_cnt + LEN_W'(1);
    total_len = len_cnt + LEN_W'(HDR_BYTES);
    in_ready  = (state == ST_IDLE) || (state == ST_DATA) || (state == ST_DRAIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      first_pg    <= '0;
      limit_pg    <= '0;
      bound_pg    <= '0;
      cur_pg      <= '0;
      next_pg_r   <= '0;
      wr_addr     <= '0;
      len_cnt     <= '0;
      hdr_idx     <= '0;
      mem_we_r    <= 1'b0;
      mem_addr_r  <= '0;
      mem_wdata_r <= '0;
      irq_r       <= 1'b0;
    end else begin
      mem_we_r <= 1'b0;
      irq_r    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            if (room_ok) begin
              mem_we_r    <= 1'b1;
              mem_addr_r  <= base_addr + ADDR_W'(HDR_BYTES);
              mem_wdata_r <= in_data;
              wr_addr     <= base_addr + ADDR_W'(HDR_BYTES + 1);
              len_cnt     <= LEN_W'(1);
              hdr_idx     <= '0;
              if (!in_last) state <= ST_DATA;
              else state <= (LEN_W'(1) < LEN_W'(MIN_FRAME)) ? ST_PAD : ST_HDR;
            end else if (!in_last) begin
              state <= ST_DRAIN;
            end
          end else if (cfg_we) begin
            case (rxr_cfg_e'(cfg_sel))
              CFG_FIRST: first_pg <= cfg_data;
              CFG_LIMIT: limit_pg <= cfg_data;
              CFG_BOUND: bound_pg <= cfg_data;
              default:   cur_pg   <= cfg_data;
            endcase
          end
        end
        ST_DATA: begin
          if (in_valid) begin
            mem_we_r    <= 1'b1;
            mem_addr_r  <= wr_addr;
            mem_wdata_r <= in_data;
            wr_addr     <= wr_next;
            len_cnt     <= len_inc;
            if (in_last) state <= (len_inc < LEN_W'(MIN_FRAME)) ? ST_PAD : ST_HDR;
          end
        end
        ST_PAD: begin
          mem_we_r    <= 1'b1;
          mem_addr_r  <= wr_addr;
          mem_wdata_r <= 8'h00;
          wr_addr     <= wr_next;
          len_cnt     <= len_inc;
          if (len_inc >= LEN_W'(MIN_FRAME)) state <= ST_HDR;
        end
        ST_HDR: begin
          mem_we_r   <= 1'b1;
          mem_addr_r <= base_addr + ADDR_W'(hdr_idx);
          hdr_idx    <= hdr_idx + 2'd1;
          case (hdr_idx)
            2'd0: begin
              mem_wdata_r <= RX_STATUS_OK;
              next_pg_r   <= next_comb;
            end
            2'd1: mem_wdata_r <= 8'(next_pg_r);
            2'd2: mem_wdata_r <= total_len[7:0];
            default: begin
              mem_wdata_r <= 8'(total_len >> 8);
              cur_pg      <= next_pg_r;
              irq_r       <= 1'b1;
              state       <= ST_IDLE;
            end
          endcase
        end
        ST_DRAIN: begin
          if (in_valid && in_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_we    = mem_we_r;
  assign mem_addr  = mem_addr_r;
  assign mem_wdata = mem_wdata_r;
  assign cur_page  = cur_pg;
  assign rx_irq    = irq_r;

  // R7
  ring_bounds_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr >= {first_pg, {OFF_W{1'b0}}}) && (mem_addr < {limit_pg, {OFF_W{1'b0}}}));

  // R8
  irq_with_last_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> mem_we && (mem_addr[OFF_W-1:0] == OFF_W'(3)));

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  // R6
  next_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR && hdr_idx == 2'd1) |-> (next_pg_r >= first_pg) && (next_pg_r < limit_pg));

  // R2
  cur_move_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_pg != $past(cur_pg)) |-> rx_irq ||
      $past(cfg_we && cfg_sel == 2'd3 && state == ST_IDLE && !in_valid));

  // R9
  drain_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN) |-> !mem_we);
endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
  typedef struct packed {
    logic        en;
    logic [7:0]  st;
    logic [7:0]  sp;
    logic [7:0]  bd;
    logic [7:0]  cu;
    logic [15:0] len;
    logic        acc;
    logic [7:0]  nx;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h02, 8'h12, 8'h02, 8'h02, 16'd100,  1'b1, 8'h03},
    '{1'b1, 8'h02, 8'h12, 8'h02, 8'h03, 16'd40,   1'b1, 8'h04},
    '{1'b1, 8'h02, 8'h12, 8'h02, 8'h10, 16'd600,  1'b0, 8'h10},
    '{1'b1, 8'h02, 8'h12, 8'h08, 8'h10, 16'd600,  1'b1, 8'h03},
    '{1'b1, 8'h02, 8'h12, 8'h0A, 8'h05, 16'd300,  1'b0, 8'h05},
    '{1'b1, 8'h02, 8'h12, 8'h0B, 8'h05, 16'd1514, 1'b1, 8'h0B},
    '{1'b1, 8'h02, 8'h12, 8'h02, 8'h02, 16'd248,  1'b1, 8'h03},
    '{1'b1, 8'h02, 8'h12, 8'h02, 8'h02, 16'd249,  1'b1, 8'h04},
    '{1'b1, 8'h05, 8'h05, 8'h02, 8'h05, 16'd100,  1'b0, 8'h05},
    '{1'b0, 8'h02, 8'h12, 8'h02, 8'h02, 16'd100,  1'b0, 8'h02},
    '{1'b1, 8'h02, 8'h12, 8'h11, 8'h11, 16'd300,  1'b1, 8'h03}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_run = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_data = '0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready, mem_we, rx_irq;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, cur_page;

  int checks = 0;
  int fails = 0;
  int wr_cnt = 0;
  int irq_cnt = 0;
  int irq_aligned = 0;
  logic [7:0] bmem [0:8191];

  rx_ring_writer u_rx_ring_writer (
    .clk(clk), .rst(rst), .rx_run(rx_run), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_page(cur_page), .rx_irq(rx_irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) begin
      bmem[mem_addr[12:0]] <= mem_wdata;
      wr_cnt = wr_cnt + 1;
    end
    if (rx_irq) begin
      irq_cnt = irq_cnt + 1;
      if (mem_we && mem_addr[7:0] == 8'd3) irq_aligned = irq_aligned + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_bytes(input int k0, input int cnt, input int len, input int seed);
    for (int k = k0; k < k0 + cnt; k++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(seed * 7 + k);
      in_last  = (k == len - 1);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  function automatic int slot(input int st, input int sp, input int cu, input int k);
    int a;
    a = cu * 256 + 4 + k;
    if (a >= sp * 256) a = a - (sp - st) * 256;
    return a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int w0, i0, a0, stored, total, bad_pay, bad_pad, base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cur_page == 8'h00, "R1 cur_page", cur_page, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(mem_we == 1'b0, "R1 mem_we", mem_we, 0);
    check(rx_irq == 1'b0, "R1 rx_irq", rx_irq, 0);
    // R1 pointers all zero: frame refused
    rx_run = 1'b1;
    w0 = wr_cnt;
    send_bytes(0, 20, 20, 1);
    repeat (10) @(negedge clk);
    check(wr_cnt == w0, "R1 refused after reset", wr_cnt - w0, 0);

    for (int v = 0; v < NV; v++) begin
      rx_run = VEC[v].en;
      cfg_write(2'd0, VEC[v].st);
      cfg_write(2'd1, VEC[v].sp);
      cfg_write(2'd2, VEC[v].bd);
      cfg_write(2'd3, VEC[v].cu);
      for (int m = 0; m < 8192; m++) bmem[m] = 8'hEE;
      w0 = wr_cnt; i0 = irq_cnt; a0 = irq_aligned;
      send_bytes(0, int'(VEC[v].len), int'(VEC[v].len), v + 1);
      repeat (80) @(negedge clk);
      check(cur_page == VEC[v].nx, "R6 cur_page after frame", cur_page, VEC[v].nx);
      if (VEC[v].acc) begin
        stored = (VEC[v].len < 60) ? 60 : int'(VEC[v].len);
        total  = stored + 4;
        base   = int'(VEC[v].cu) * 256;
        check(irq_cnt - i0 == 1, "R8 irq count", irq_cnt - i0, 1);
        check(irq_aligned - a0 == 1, "R8 irq with header byte 3", irq_aligned - a0, 1);
        check(wr_cnt - w0 == total, "R3 write count", wr_cnt - w0, total);
        check(bmem[base] == 8'h01, "R5 status", bmem[base], 1);
        check(bmem[base + 1] == VEC[v].nx, "R5 next page", bmem[base + 1], VEC[v].nx);
        check(bmem[base + 2] == 8'(total), "R5 length low", bmem[base + 2], total % 256);
        check(bmem[base + 3] == 8'(total >> 8), "R5 length high", bmem[base + 3], total / 256);
        bad_pay = 0; bad_pad = 0;
        for (int k = 0; k < stored; k++) begin
          int a;
          a = slot(VEC[v].st, VEC[v].sp, VEC[v].cu, k);
          if (k < int'(VEC[v].len)) begin
            if (bmem[a] != 8'((v + 1) * 7 + k)) bad_pay++;
          end else if (bmem[a] != 8'h00) bad_pad++;
        end
        check(bad_pay == 0, "R3/R7 payload placement", bad_pay, 0);
        check(bad_pad == 0, "R4 zero padding", bad_pad, 0);
      end else begin
        check(wr_cnt == w0, "R9/R10 no writes on refusal", wr_cnt - w0, 0);
        check(irq_cnt == i0, "R9/R10 no irq on refusal", irq_cnt - i0, 0);
        check(in_ready == 1'b1, "R9 drained", in_ready, 1);
      end
    end

    // R11 in_ready low during padding, back after header
    rx_run = 1'b1;
    cfg_write(2'd0, 8'h02);
    cfg_write(2'd1, 8'h12);
    cfg_write(2'd2, 8'h02);
    cfg_write(2'd3, 8'h02);
    send_bytes(0, 10, 10, 3);
    check(in_ready == 1'b0, "R11 in_ready during pad", in_ready, 0);
    repeat (80) @(negedge clk);
    check(in_ready == 1'b1, "R11 in_ready after header", in_ready, 1);
    check(cur_page == 8'h03, "R4 short frame next page", cur_page, 3);

    // R2 configuration write ignored mid-frame
    cfg_write(2'd3, 8'h02);
    send_bytes(0, 10, 70, 4);
    cfg_write(2'd3, 8'h09);
    send_bytes(10, 60, 70, 4);
    repeat (40) @(negedge clk);
    check(cur_page == 8'h03, "R2 mid-frame write ignored", cur_page, 3);
    cfg_write(2'd3, 8'h07);
    check(cur_page == 8'h07, "R2 idle write applied", cur_page, 7);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule